// File: doc/BRIEF.md
# Multi-mode timer/event counter

This block is a programmable up-counter, CNT_W bits wide (8 by default, 16 for the wide instance), that raises a sticky overflow interrupt request. Software sets it up through a small register port with three addressable words: a control word, a preload word and the live count, which is read-only. A two-bit mode field selects the count source. The counter can count edges on an external pin, count cycles of an internal clock enable (the prescaled tick, generated outside the block), or measure how long the external pin stays at its active level.

When the count passes all-ones it reloads from the preload word and sets the overflow flag. The flag drives the interrupt request and stays set until software writes the control word with that bit at 0. The external pin passes through a flip-flop synchroniser before any edge or level is used. In pulse-width mode, the block clears its own run bit when the pin returns to its inactive level, so the measured width stays frozen in the count register until software reads it.

Top module: `evt_timer`

## Requirements
- R1: After reset, the control, preload and count words all read 0 and irq_o is low.
- R2: Mode field, control bits [3:2]: 00 idle, 01 external edge count, 10 internal tick count, 11 pulse-width measurement. In idle the count does not change even when the run bit is 1.
- R3: Control bit 0 is the run bit. While it is 0 the count holds its value whatever the mode and inputs.
- R4: In mode 10 with run set, the count increments by one on each clock cycle in which clk_en_i is high.
- R5: In mode 01 with run set, the count increments once per active edge of evt_pin_i. Control bit 1 at 0 selects rising edges and at 1 selects falling edges. A pin change made between clock edges shows in the count after the third following rising clock edge, and not after the second.
- R6: In mode 11 with run set, the count increments on each cycle with clk_en_i high while the synchronised pin is at its active level: high when bit 1 is 0, low when bit 1 is 1.
- R7: In mode 11 with run set, a synchronised transition of the pin from the active to the inactive level clears the run bit. The count then stays frozen even if the pin becomes active again.
- R8: An increment from all-ones loads the count with the preload value held before that cycle, sets the overflow flag (control bit 4) and drives irq_o high.
- R9: The overflow flag is sticky. A control write with bit 4 at 0 clears it, and a control write with bit 4 at 1 leaves it unchanged. If an overflow happens in the same cycle as a clearing write, the flag stays set.
- R10: A write to address 1 sets the preload. If the run bit is 0 at that moment, the count takes the same value. If the run bit is 1, the count is not touched.
- R11: Read map: address 0 returns the control word (bit 0 run, bit 1 edge select, bits [3:2] mode, bit 4 flag, other bits 0), address 1 the preload, address 2 the count, and address 3 zero. Written control bits above bit 4 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 preload |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | CNT_W | Read data for rd_addr_i, combinational |
| evt_pin_i | input | 1 | External event / gate pin, asynchronous |
| clk_en_i | input | 1 | Internal prescaled count enable |
| irq_o | output | 1 | Overflow interrupt request (sticky flag) |

## Verification
The hardest case to reach is a wrap that lands in the same cycle as a control write that clears the flag. The bench loads all-ones through a preload write while the counter is stopped, starts the timer with clk_en_i low, and then raises clk_en_i in the exact cycle it repeats the clearing write. The self-stop in pulse-width mode is also delicate, because the pin must cross the synchroniser. The bench holds the pin active for a known number of cycles and checks that the count equals that number, that the run bit has cleared, and that a later active phase adds nothing. A behavioural model compares the selected read word and irq_o on every clock while the read address cycles.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  // packed order gives bit 4 flag, [3:2] mode, 1 edge, 0 run
  typedef struct packed {
    logic      flag;
    tmr_mode_e mode;
    logic      edge_fall;
    logic      run;
  } tmr_ctrl_t;

  localparam int CTRL_W = 5;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PRE  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign lvl_o = chain_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;

endmodule

// File: rtl/evt_timer_count.sv
module evt_timer_count
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmr_ctrl_t        ctrl_i,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             clk_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             pw_end_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             active_lvl;
  logic             src_hit;
  logic             tick;

  assign active_lvl = ~ctrl_i.edge_fall;

  always_comb begin
    unique case (ctrl_i.mode)
      MODE_EVENT: src_hit = ctrl_i.edge_fall ? fall_i : rise_i;
      MODE_TIMER: src_hit = clk_en_i;
      MODE_PULSE: src_hit = clk_en_i & (lvl_i == active_lvl);
      default:    src_hit = 1'b0;
    endcase
  end

  assign tick   = ctrl_i.run & src_hit;
  assign wrap_o = tick & (cnt_q == '1);

  // gate returns to inactive level: active-high ends on fall, active-low on rise
  assign pw_end_o = ctrl_i.run & (ctrl_i.mode == MODE_PULSE) &
                    (ctrl_i.edge_fall ? rise_i : fall_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick)   cnt_q <= wrap_o ? preload_i : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             wrap_i,
  input  logic             pw_end_i,
  output tmr_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0] preload_o,
  output logic             load_o
);

  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] pre_q;
  logic             wr_ctrl;
  logic             wr_pre;

  assign wr_ctrl = wr_en_i & (wr_addr_i == ADDR_CTRL);
  assign wr_pre  = wr_en_i & (wr_addr_i == ADDR_PRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.run       <= 1'b0;
      ctrl_q.edge_fall <= 1'b0;
      ctrl_q.mode      <= MODE_IDLE;
    end else if (wr_ctrl) begin
      ctrl_q.run       <= wr_data_i[0];
      ctrl_q.edge_fall <= wr_data_i[1];
      ctrl_q.mode      <= tmr_mode_e'(wr_data_i[3:2]);
    end else if (pw_end_i) begin
      ctrl_q.run       <= 1'b0;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ctrl_q.flag <= 1'b0;
    else if (wrap_i)                  ctrl_q.flag <= 1'b1;
    else if (wr_ctrl && !wr_data_i[4]) ctrl_q.flag <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (wr_pre) pre_q <= wr_data_i;
  end

  assign load_o    = wr_pre & ~ctrl_q.run;
  assign ctrl_o    = ctrl_q;
  assign preload_o = pre_q;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             evt_pin_i,
  input  logic             clk_en_i,
  output logic             irq_o
);

  localparam int PAD_W = CNT_W - CTRL_W;

  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] pre_w;
  logic [CNT_W-1:0] cnt_w;
  logic             lvl_w, rise_w, fall_w;
  logic             wrap_w, pw_end_w, load_w;

  evt_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (evt_pin_i),
    .lvl_o  (lvl_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  evt_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wrap_i    (wrap_w),
    .pw_end_i  (pw_end_w),
    .ctrl_o    (ctrl_q),
    .preload_o (pre_w),
    .load_o    (load_w)
  );

  evt_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl_q),
    .lvl_i      (lvl_w),
    .rise_i     (rise_w),
    .fall_i     (fall_w),
    .clk_en_i   (clk_en_i),
    .load_i     (load_w),
    .load_val_i (wr_data_i),
    .preload_i  (pre_w),
    .cnt_o      (cnt_w),
    .wrap_o     (wrap_w),
    .pw_end_o   (pw_end_w)
  );

  always_comb begin
    unique case (rd_addr_i)
      ADDR_CTRL: rd_data_o = {{PAD_W{1'b0}}, ctrl_q};
      ADDR_PRE:  rd_data_o = pre_w;
      ADDR_CNT:  rd_data_o = cnt_w;
      default:   rd_data_o = '0;
    endcase
  end

  assign irq_o = ctrl_q.flag;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             clk_en_i,
  input logic             irq_o,
  input logic             run,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preload
);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b00 && !wr_en_i) |=> $stable(cnt));

  p_stopped_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_en_i) |=> $stable(cnt));

  p_timer_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && mode == 2'b10 && clk_en_i && cnt != '1 && !wr_en_i)
      |=> (cnt - $past(cnt)) == CNT_W'(1));

  p_wrap_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && mode == 2'b10 && clk_en_i && cnt == '1)
      |=> (cnt == $past(preload) && irq_o));

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr_en_i && wr_addr_i == 2'd0)) |=> irq_o);

  p_stopped_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && wr_en_i && wr_addr_i == 2'd1) |=> cnt == $past(wr_data_i));

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .clk_en_i  (clk_en_i),
  .irq_o     (irq_o),
  .run       (ctrl_q.run),
  .mode      (ctrl_q.mode),
  .cnt       (cnt_w),
  .preload   (pre_w)
);

// File: tb/evt_timer_bench.sv
`timescale 1ns/1ps
module evt_timer_bench;
  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         pin = 1'b0;
  logic         clk_en = 1'b0;
  logic         irq;

  always #2 clk = ~clk;

  evt_timer #(.CNT_W(W)) u_evt_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .evt_pin_i(pin), .clk_en_i(clk_en), .irq_o(irq)
  );

  int    checks = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference state
  int m_s1 = 0, m_s2 = 0, m_prev = 0;
  int m_run = 0, m_edge = 0, m_mode = 0, m_flag = 0, m_pre = 0, m_cnt = 0;

  function automatic int model_rd(int a);
    case (a)
      0: return (m_flag << 4) | (m_mode << 2) | (m_edge << 1) | m_run;
      1: return m_pre;
      2: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_run = 0; m_edge = 0;
      m_mode = 0; m_flag = 0; m_pre = 0; m_cnt = 0;
    end else begin
      int act, tick, stop, wrapped, n_cnt, n_flag, n_run, d;
      act = m_edge ? 0 : 1;
      tick = 0;
      if (m_run != 0) begin
        if (m_mode == 1) tick = m_edge ? (m_s2 == 0 && m_prev == 1) : (m_s2 == 1 && m_prev == 0);
        if (m_mode == 2) tick = clk_en;
        if (m_mode == 3) tick = clk_en && (m_s2 == act);
      end
      stop = (m_run != 0) && m_mode == 3 && m_prev == act && m_s2 != act;
      wrapped = tick && m_cnt == MAXV;
      n_cnt = m_cnt; n_flag = m_flag; n_run = m_run;
      if (tick) begin
        if (wrapped) begin n_cnt = m_pre; n_flag = 1; end
        else n_cnt = m_cnt + 1;
      end
      if (stop) n_run = 0;
      d = int'(wr_data);
      if (wr_en && wr_addr == 2'd0) begin
        n_run = d & 1; m_edge = (d >> 1) & 1; m_mode = (d >> 2) & 3;
        if (((d >> 4) & 1) == 0 && !wrapped) n_flag = 0;
      end
      if (wr_en && wr_addr == 2'd1) begin
        if (m_run == 0) n_cnt = d;
        m_pre = d;
      end
      m_cnt = n_cnt; m_flag = n_flag; m_run = n_run;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(pin);
    end
  end

  task automatic chk(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk({cur_req, " model rd"}, int'(rd_data), model_rd(int'(rd_addr)));
      chk({cur_req, " model irq"}, int'(irq), m_flag);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, int exp_v, string req);
    rd_addr = a;
    #1;
    chk(req, int'(rd_data), exp_v);
  endtask

  task automatic pulse();
    @(negedge clk); pin = 1'b1;
    cyc(4); pin = 1'b0;
    cyc(4);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R1";
    rd_chk(2'd0, 0, "R1 ctrl");
    rd_chk(2'd1, 0, "R1 preload");
    rd_chk(2'd2, 0, "R1 count");
    chk("R1 irq", int'(irq), 0);

    cur_req = "R2";
    wr(2'd0, 8'h01); clk_en = 1'b1; cyc(6); clk_en = 1'b0;
    rd_chk(2'd2, 0, "R2 idle holds");

    cur_req = "R10";
    wr(2'd0, 8'h00); wr(2'd1, 8'hF0);
    rd_chk(2'd2, 8'hF0, "R10 stopped load");

    cur_req = "R4";
    wr(2'd0, 8'h09); clk_en = 1'b1; cyc(5); clk_en = 1'b0;
    rd_chk(2'd2, 8'hF5, "R4 five ticks");

    cur_req = "R3";
    wr(2'd0, 8'h08); clk_en = 1'b1; cyc(5); clk_en = 1'b0;
    rd_chk(2'd2, 8'hF5, "R3 frozen");

    cur_req = "R8";
    wr(2'd1, 8'hFD); wr(2'd0, 8'h09); clk_en = 1'b1; cyc(3); clk_en = 1'b0;
    rd_chk(2'd2, 8'hFD, "R8 reload");
    chk("R8 irq", int'(irq), 1);
    rd_chk(2'd0, 8'h19, "R8 flag bit");

    cur_req = "R9";
    wr(2'd0, 8'h19);
    rd_chk(2'd0, 8'h19, "R9 write one keeps");
    wr(2'd0, 8'h08);
    chk("R9 cleared irq", int'(irq), 0);

    cur_req = "R10";
    wr(2'd0, 8'h09); wr(2'd1, 8'h10);
    rd_chk(2'd1, 8'h10, "R10 preload running");
    rd_chk(2'd2, 8'hFD, "R10 count untouched");

    cur_req = "R9";
    wr(2'd0, 8'h00); wr(2'd1, 8'hFF); wr(2'd0, 8'h09);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h09; clk_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; clk_en = 1'b0;
    chk("R9 set beats clear", int'(irq), 1);
    rd_chk(2'd2, 8'hFF, "R9 wrap reload");
    wr(2'd0, 8'h08);

    cur_req = "R5";
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h05);
    rd_addr = 2'd2;
    @(negedge clk); pin = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk("R5 not after 2nd edge", int'(rd_data), 0);
    @(posedge clk); #1;
    chk("R5 after 3rd edge", int'(rd_data), 1);
    @(negedge clk); pin = 1'b0; cyc(4);
    rd_chk(2'd2, 1, "R5 fall ignored");
    pulse(); pulse();
    rd_chk(2'd2, 3, "R5 rising count");
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h07);
    pulse(); pulse();
    rd_chk(2'd2, 2, "R5 falling count");

    cur_req = "R6";
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h0D);
    clk_en = 1'b1; cyc(5);
    rd_chk(2'd2, 0, "R6 inactive no count");
    @(negedge clk); pin = 1'b1; cyc(6); pin = 1'b0; cyc(6);
    rd_chk(2'd2, 6, "R6 width high");
    cur_req = "R7";
    rd_chk(2'd0, 8'h0C, "R7 run cleared");
    pin = 1'b1; cyc(6); pin = 1'b0; cyc(4);
    rd_chk(2'd2, 6, "R7 stays frozen");
    clk_en = 1'b0;

    cur_req = "R6";
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    pin = 1'b1; cyc(4);
    wr(2'd0, 8'h0F); clk_en = 1'b1; cyc(3);
    rd_chk(2'd2, 0, "R6 active-low idle high");
    pin = 1'b0; cyc(4); pin = 1'b1; cyc(6);
    rd_chk(2'd2, 4, "R6 width low");
    rd_chk(2'd0, 8'h0E, "R7 active-low stop");
    clk_en = 1'b0;

    cur_req = "R11";
    rd_chk(2'd3, 0, "R11 unused address");
    wr(2'd0, 8'hE2);
    rd_chk(2'd0, 8'h02, "R11 upper bits dropped");

    cur_req = "R4";
    wr(2'd1, 8'hF8); wr(2'd0, 8'h09);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      clk_en = (i % 3) != 0;
      rd_addr = 2'(i % 3);
    end
    @(negedge clk); clk_en = 1'b0;
    wr(2'd0, 8'h08);
    cyc(2);

    finish_run();
  end
endmodule